// File: doc/BRIEF.md
# Real-Time Clock Event and Alarm Interrupt Unit

This unit turns a once-per-second tick into three kinds of timekeeping events and folds them onto a single interrupt line. It keeps its own seconds, minutes and hours counters. Every tick is a seconds event. A tick that wraps the seconds counter is also a minutes event. When that wrap carries the time into a minute whose minute and hour both equal two programmable targets, the tick is also an alarm event. Each event source has its own sticky flag and its own enable. The interrupt output is high while any enabled flag is set.

Software programs the alarm through two write ports, one for the target minute and one for the target hour. It clears flags with a write-one-to-clear pulse vector. The tick comes from an external prescaler and lasts one clock cycle per second. All pins are plain control and status signals. No data stream crosses the block's edge, so none of its pins uses a valid/ready handshake and the block never applies back-pressure.

Flag vector layout, used by both `flags_q` and `flag_clr`: bit 0 is the seconds event, bit 1 the minutes event, bit 2 the alarm.

Top module: `rtc_evt_irq`

## Requirements
- R1: While `rst_n` is low, and in the cycles after it is released with no other stimulus, `sec_q`, `min_q`, `hr_q`, `tgt_min_q`, `tgt_hr_q` and `flags_q` are all 0 and `irq` is 0.
- R2: Each clock edge that samples `sec_tick` high advances `sec_q` through 0..59, wrapping to 0. A seconds wrap advances `min_q` through 0..59, and a minutes wrap advances `hr_q` through 0..23, each wrapping to 0. With `sec_tick` low, the time does not change.
- R3: Every clock edge that samples `sec_tick` high sets `flags_q[0]`.
- R4: A clock edge that samples `sec_tick` high while `sec_q` is 59 sets `flags_q[1]`, in the same edge that `sec_q` becomes 0.
- R5: `flags_q[2]` is set only at a seconds wrap after which `min_q` equals `tgt_min_q` and `hr_q` equals `tgt_hr_q`. It is not set again while that match persists. Writing targets equal to the current time does not set it.
- R6: A cycle with `tgt_min_wr` high loads the 6-bit `tgt_min_wdata` into `tgt_min_q`. A cycle with `tgt_hr_wr` high loads the 5-bit `tgt_hr_wdata` into `tgt_hr_q`. The new value is visible after that edge.
- R7: A set flag stays set until a cycle in which its `flag_clr` bit is 1. That cycle clears only the flagged bit whose clear bit is 1.
- R8: When an event and a clear of the same flag occur in the same cycle, the flag is 1 after that edge.
- R9: `irq` equals the OR over the three bits of (`flags_q` AND `evt_en`). `evt_en` has no effect on the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| tgt_min_wr | input | 1 | Load the target minute |
| tgt_min_wdata | input | 6 | Target minute write value |
| tgt_hr_wr | input | 1 | Load the target hour |
| tgt_hr_wdata | input | 5 | Target hour write value |
| evt_en | input | 3 | Per-source interrupt enables (bit 0 seconds, bit 1 minutes, bit 2 alarm) |
| flag_clr | input | 3 | Write-one-to-clear pulses for the flags |
| tgt_min_q | output | 6 | Current target minute |
| tgt_hr_q | output | 5 | Current target hour |
| sec_q | output | 6 | Seconds count |
| min_q | output | 6 | Minutes count |
| hr_q | output | 5 | Hours count |
| flags_q | output | 3 | Sticky event flags |
| irq | output | 1 | Shared interrupt |

## Verification
Every result lands one edge after its cause. The counters, all three flags and both targets update on the edge that samples the tick, clear or write, and `irq` follows the flags with no further delay. The bench therefore drives each stimulus for exactly one edge and samples a quarter period after that edge. Its arithmetic time and flag model advances at the same edge, so each sample is compared against the model's state at that instant. The sweep covers more than a full day of ticks, including the midnight wrap, an alarm at the midnight match, and a period where the targets equal a time already in progress.

// File: rtl/rtc_evt_pkg.sv
package rtc_evt_pkg;
  localparam int N_EVT   = 3;
  localparam int EVT_SEC = 0;
  localparam int EVT_MIN = 1;
  localparam int EVT_ALM = 2;
  localparam int DEF_SEC_MOD = 60;
  localparam int DEF_MIN_MOD = 60;
  localparam int DEF_HR_MOD  = 24;
endpackage

// File: rtl/rtc_wrap_cnt.sv
module rtc_wrap_cnt #(
  parameter int MODULO = 60,
  parameter int W = $clog2(MODULO)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nxt,
  output logic         wrap
);
  localparam logic [W-1:0] LAST = W'(MODULO - 1);

  assign wrap = inc && (cnt == LAST);

  always_comb begin
    if (!inc)            cnt_nxt = cnt;
    else if (cnt == LAST) cnt_nxt = '0;
    else                 cnt_nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int MW = 6,
  parameter int HW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tmin_wr,
  input  logic [MW-1:0] tmin_wdata,
  input  logic          thr_wr,
  input  logic [HW-1:0] thr_wdata,
  input  logic          min_boundary,
  input  logic [MW-1:0] min_nxt,
  input  logic [HW-1:0] hr_nxt,
  output logic [MW-1:0] tmin_q,
  output logic [HW-1:0] thr_q,
  output logic          alarm_evt
);
  // The match is tested only when the time is about to enter a new minute,
  // so a match that persists or is created by a target write never re-fires.
  assign alarm_evt = min_boundary && (min_nxt == tmin_q) && (hr_nxt == thr_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmin_q <= '0;
      thr_q  <= '0;
    end else begin
      if (tmin_wr) tmin_q <= tmin_wdata;
      if (thr_wr)  thr_q  <= thr_wdata;
    end
  end
endmodule

// File: rtl/rtc_evt_flags.sv
module rtc_evt_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] pend;

  for (genvar i = 0; i < N; i++) begin : g_flag
    // A new event takes precedence over a clear in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flags[i] <= 1'b0;
      else if (evt[i]) flags[i] <= 1'b1;
      else if (clr[i]) flags[i] <= 1'b0;
    end
    assign pend[i] = flags[i] & en[i];
  end

  assign irq = |pend;
endmodule

// File: rtl/rtc_evt_irq.sv
module rtc_evt_irq
  import rtc_evt_pkg::*;
#(
  parameter int SEC_MOD = DEF_SEC_MOD,
  parameter int MIN_MOD = DEF_MIN_MOD,
  parameter int HR_MOD  = DEF_HR_MOD,
  localparam int SEC_W = $clog2(SEC_MOD),
  localparam int MIN_W = $clog2(MIN_MOD),
  localparam int HR_W  = $clog2(HR_MOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_tick,
  input  logic             tgt_min_wr,
  input  logic [MIN_W-1:0] tgt_min_wdata,
  input  logic             tgt_hr_wr,
  input  logic [HR_W-1:0]  tgt_hr_wdata,
  input  logic [N_EVT-1:0] evt_en,
  input  logic [N_EVT-1:0] flag_clr,
  output logic [MIN_W-1:0] tgt_min_q,
  output logic [HR_W-1:0]  tgt_hr_q,
  output logic [SEC_W-1:0] sec_q,
  output logic [MIN_W-1:0] min_q,
  output logic [HR_W-1:0]  hr_q,
  output logic [N_EVT-1:0] flags_q,
  output logic             irq
);
  logic [SEC_W-1:0] sec_nxt;
  logic [MIN_W-1:0] min_nxt;
  logic [HR_W-1:0]  hr_nxt;
  logic sec_wrap, min_wrap, hr_wrap;
  logic alarm_evt;
  logic [N_EVT-1:0] evt;

  rtc_wrap_cnt #(.MODULO(SEC_MOD), .W(SEC_W)) u_sec (
    .clk(clk), .rst_n(rst_n), .inc(sec_tick),
    .cnt(sec_q), .cnt_nxt(sec_nxt), .wrap(sec_wrap));

  rtc_wrap_cnt #(.MODULO(MIN_MOD), .W(MIN_W)) u_min (
    .clk(clk), .rst_n(rst_n), .inc(sec_wrap),
    .cnt(min_q), .cnt_nxt(min_nxt), .wrap(min_wrap));

  rtc_wrap_cnt #(.MODULO(HR_MOD), .W(HR_W)) u_hr (
    .clk(clk), .rst_n(rst_n), .inc(min_wrap),
    .cnt(hr_q), .cnt_nxt(hr_nxt), .wrap(hr_wrap));

  rtc_alarm_cmp #(.MW(MIN_W), .HW(HR_W)) u_alarm (
    .clk(clk), .rst_n(rst_n),
    .tmin_wr(tgt_min_wr), .tmin_wdata(tgt_min_wdata),
    .thr_wr(tgt_hr_wr), .thr_wdata(tgt_hr_wdata),
    .min_boundary(sec_wrap), .min_nxt(min_nxt), .hr_nxt(hr_nxt),
    .tmin_q(tgt_min_q), .thr_q(tgt_hr_q), .alarm_evt(alarm_evt));

  always_comb begin
    evt          = '0;
    evt[EVT_SEC] = sec_tick;
    evt[EVT_MIN] = sec_wrap;
    evt[EVT_ALM] = alarm_evt;
  end

  rtc_evt_flags #(.N(N_EVT)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt), .clr(flag_clr), .en(evt_en),
    .flags(flags_q), .irq(irq));

  logic unused_ok;
  assign unused_ok = &{1'b0, hr_wrap, sec_nxt};
endmodule

// File: rtl/rtc_evt_irq_chk.sv
module rtc_evt_irq_chk
  import rtc_evt_pkg::*;
#(
  parameter int SEC_MOD = DEF_SEC_MOD,
  parameter int MIN_MOD = DEF_MIN_MOD,
  parameter int HR_MOD  = DEF_HR_MOD,
  localparam int SEC_W = $clog2(SEC_MOD),
  localparam int MIN_W = $clog2(MIN_MOD),
  localparam int HR_W  = $clog2(HR_MOD)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sec_tick,
  input logic             tgt_min_wr,
  input logic [MIN_W-1:0] tgt_min_wdata,
  input logic             tgt_hr_wr,
  input logic [HR_W-1:0]  tgt_hr_wdata,
  input logic [N_EVT-1:0] evt_en,
  input logic [N_EVT-1:0] flag_clr,
  input logic [MIN_W-1:0] tgt_min_q,
  input logic [HR_W-1:0]  tgt_hr_q,
  input logic [SEC_W-1:0] sec_q,
  input logic [MIN_W-1:0] min_q,
  input logic [HR_W-1:0]  hr_q,
  input logic [N_EVT-1:0] flags_q,
  input logic             irq
);
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SEC_MOD - 1);

  assert_time_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(sec_q) < SEC_MOD) && (32'(min_q) < MIN_MOD) && (32'(hr_q) < HR_MOD));

  assert_time_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> ($stable(sec_q) && $stable(min_q) && $stable(hr_q)));

  assert_sec_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> flags_q[EVT_SEC]);

  assert_min_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && sec_q == SEC_LAST) |=> (flags_q[EVT_MIN] && sec_q == '0));

  assert_alarm_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flags_q[EVT_ALM]) && $past(!tgt_min_wr && !tgt_hr_wr)) |->
      (sec_q == '0 && min_q == tgt_min_q && hr_q == tgt_hr_q));

  for (genvar k = 0; k < N_EVT; k++) begin : g_sticky
    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flags_q[k] && !flag_clr[k]) |=> flags_q[k]);
  end

  assert_sec_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr[EVT_SEC] && !sec_tick) |=> !flags_q[EVT_SEC]);

  assert_clear_race_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr[EVT_SEC] && sec_tick) |=> flags_q[EVT_SEC]);

  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q == '0) |-> !irq);

  logic unused_ok;
  assign unused_ok = &{1'b0, tgt_min_wdata, tgt_hr_wdata, evt_en};
endmodule

bind rtc_evt_irq rtc_evt_irq_chk #(
  .SEC_MOD(SEC_MOD), .MIN_MOD(MIN_MOD), .HR_MOD(HR_MOD)
) u_chk (.*);

// File: tb/tb_rtc_evt_irq.sv
module tb_rtc_evt_irq;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 1'b0;
  logic tgt_min_wr = 1'b0;
  logic [5:0] tgt_min_wdata = '0;
  logic tgt_hr_wr = 1'b0;
  logic [4:0] tgt_hr_wdata = '0;
  logic [2:0] evt_en = '0;
  logic [2:0] flag_clr = '0;
  logic [5:0] tgt_min_q;
  logic [4:0] tgt_hr_q;
  logic [5:0] sec_q;
  logic [5:0] min_q;
  logic [4:0] hr_q;
  logic [2:0] flags_q;
  logic irq;

  rtc_evt_irq dut (.*);

  always #(CLK_P/2) clk = ~clk;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;
  int ms = 0, mm = 0, mh = 0, mtm = 0, mth = 0;
  logic [2:0] mf = '0;

  task automatic chk(input string rq, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk("R2 time", int'(hr_q) * 3600 + int'(min_q) * 60 + int'(sec_q), mh * 3600 + mm * 60 + ms);
    chk("R3 seconds flag", int'(flags_q[0]), int'(mf[0]));
    chk("R4 minutes flag", int'(flags_q[1]), int'(mf[1]));
    chk("R5 alarm flag", int'(flags_q[2]), int'(mf[2]));
    chk("R9 irq", int'(irq), int'(|(mf & evt_en)));
  endtask

  task automatic cyc(input bit t, input logic [2:0] c);
    logic [2:0] ev;
    sec_tick = t;
    flag_clr = c;
    @(posedge clk);
    ev = '0;
    if (t) begin
      ev[0] = 1'b1;
      if (ms == 59) begin
        ms = 0;
        ev[1] = 1'b1;
        if (mm == 59) begin
          mm = 0;
          mh = (mh == 23) ? 0 : mh + 1;
        end else mm++;
        if (mm == mtm && mh == mth) ev[2] = 1'b1;
      end else ms++;
    end
    mf = (mf & ~c) | ev;
    #(CLK_P/4);
    sec_tick = 1'b0;
    flag_clr = '0;
    cmp_all();
  endtask

  task automatic wr_tgt(input int m, input int h);
    tgt_min_wr = 1'b1; tgt_min_wdata = 6'(m);
    tgt_hr_wr = 1'b1;  tgt_hr_wdata = 5'(h);
    @(posedge clk);
    mtm = m; mth = h;
    #(CLK_P/4);
    tgt_min_wr = 1'b0; tgt_hr_wr = 1'b0;
    chk("R6 target minute", int'(tgt_min_q), m);
    chk("R6 target hour", int'(tgt_hr_q), h);
    cmp_all();
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_P/4);
    chk("R1 reset time", int'(sec_q) + int'(min_q) + int'(hr_q), 0);
    chk("R1 reset flags", int'(flags_q), 0);
    chk("R1 reset targets", int'(tgt_min_q) + int'(tgt_hr_q), 0);
    chk("R1 reset irq", int'(irq), 0);
    rst_n = 1'b1;
    @(posedge clk); #(CLK_P/4);
    cmp_all();
    chk("R1 targets after release", int'(tgt_min_q) + int'(tgt_hr_q), 0);

    wr_tgt(45, 17);
    wr_tgt(63, 31);
    wr_tgt(2, 0);

    // Phase A: sparse ticks, mixed clears, all enables.
    evt_en = 3'b111;
    for (int i = 0; i < 200; i++)
      cyc((i % 3) != 1, (i % 11 == 0) ? 3'b111 : ((i % 5 == 0) ? 3'b001 : 3'b000));

    // R8: event and clear of the same flag in one cycle.
    cyc(1'b1, 3'b001);
    chk("R8 tick with clear keeps flag", int'(flags_q[0]), 1);

    // R7: idle cycles hold flags, then a clear of one bit only.
    cyc(1'b1, 3'b000);
    for (int i = 0; i < 3; i++) begin
      cyc(1'b0, 3'b000);
      chk("R7 flag held", int'(flags_q[0]), 1);
    end
    cyc(1'b0, 3'b001);
    chk("R7 cleared bit", int'(flags_q[0]), 0);
    chk("R7 other bit untouched", int'(flags_q[1]), int'(mf[1]));

    // R5: targets set to the minute already in progress do not fire.
    cyc(1'b0, 3'b111);
    wr_tgt(mm, mh);
    for (int i = 0; i < 30 && ms != 59; i++) cyc(1'b1, 3'b000);
    chk("R5 no fire on equal write", int'(flags_q[2]), 0);

    // R9: enables gate irq only.
    evt_en = 3'b000;
    cyc(1'b1, 3'b000);
    chk("R9 flags set with irq masked", int'(flags_q[0]), 1);
    chk("R9 irq masked", int'(irq), 0);
    evt_en = 3'b001;
    #1;
    chk("R9 irq enabled", int'(irq), 1);

    // Phase B: dense ticks to 01:10:05 with an alarm at 01:10.
    wr_tgt(10, 1);
    for (int i = 0; !(mh == 1 && mm == 10 && ms == 5); i++) begin
      evt_en = 3'(i / 1000);
      cyc(1'b1, (i % 97 == 0) ? 3'b111 : 3'b000);
    end
    chk("R5 alarm at 01:10", int'(flags_q[2]), 1);

    // Phase C: run through midnight with an alarm at 00:00.
    wr_tgt(0, 0);
    cyc(1'b0, 3'b100);
    for (int i = 0; !(mh == 0 && mm == 0 && ms == 3); i++) begin
      evt_en = 3'(i / 777);
      cyc(1'b1, (i % 89 == 0) ? 3'b011 : 3'b000);
    end
    chk("R2 midnight wrap", int'(hr_q) + int'(min_q), 0);
    chk("R5 alarm at midnight", int'(flags_q[2]), 1);

    summary();
  end
endmodule